// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This block picks one of two 64-bit double-precision operands, or a quieted NaN, under the control of a 4-bit mode. The mode chooses minimum or maximum, a plain or an absolute-value comparison, and one of four conventions for NaN inputs and signed zeros. There is no rounding anywhere in the path, so single-precision values held in double format go through it unchanged and need no mode of their own.

One operation is accepted per clock when `in_valid` is high. The result, an invalid-operation flag and a record strobe are registered and appear on the next cycle. The flag is set by signaling NaN inputs. The strobe repeats the record-form request that came with the operation. A NaN returned from a signaling input always has its quiet bit set.

Top module: `fmm_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `record` and `invalid` become 0 and `result` becomes all zeros.
- R2: `out_valid` is `in_valid` delayed by one cycle. `record` is high exactly when `out_valid` is high and the operation was issued with `rc_in` high. When `out_valid` is low, `invalid` is low.
- R3: Mode encoding: bit 0 selects maximum (1) or minimum (0). Bits 2:1 select the family: 0 number-2008, 1 NaN-propagating-2019, 2 number-2019, 3 compare-select. Bit 3 selects a magnitude comparison. For non-NaN operands that are not both zero, the result is the bit pattern of the smaller operand (min) or the larger operand (max).
- R4: With mode bit 3 set, operands are ordered by absolute value. When the absolute values are equal, the signed ordering of the same family decides.
- R5: In the two 2019 families, -0 orders below +0. In the number-2008 and compare-select families, two zeros tie, and a tie always returns operand A.
- R6: Number-2008 family: if any input is a signaling NaN, the result is that NaN quieted (A is preferred when both are). If both inputs are quiet NaNs, the result is A. If exactly one is a quiet NaN, the result is the other operand.
- R7: NaN-propagating-2019 family: any NaN input gives a NaN result, namely A quieted if A is a NaN, otherwise B quieted.
- R8: Number-2019 family: a single NaN input, quiet or signaling, gives the other operand. Two NaN inputs give A quieted.
- R9: Compare-select family: if either input is a NaN, the result is B, quieted if B is a NaN.
- R10: Quieting sets bit 51 (the top fraction bit) and keeps every other bit. A NaN on `result` always has bit 51 set.
- R11: `invalid` is high with a result exactly when either input is a signaling NaN (exponent all ones, bit 51 clear, fraction non-zero), in every family.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| rc_in | input | 1 | Record form requested for this operation |
| mode | input | 4 | Min/max mode, encoded as in R3 |
| op_a | input | 64 | Operand A, double format |
| op_b | input | 64 | Operand B, double format |
| out_valid | output | 1 | Result registers hold a new result |
| result | output | 64 | Selected operand or quieted NaN |
| invalid | output | 1 | Invalid-operation flag for the result |
| record | output | 1 | Record strobe for the result |

## Verification
The bench goes after the cases where the families differ. A design that confuses the families returns a number where a NaN must propagate, or a NaN where the other number must win. A design that gets zero ordering wrong returns +0 for a 2019 minimum of the two zeros, or returns B where A is required. A design that forgets to quiet passes a signaling NaN straight through. A design that treats magnitude ties badly returns the wrong sign for pairs like -1 and +1. Random operands drawn from a pool of infinities, zeros, both NaN kinds and ordinary numbers are compared against an order-key reference model, with every mode and record setting.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int DATA_W  = EXP_W + FRAC_W + 1;
    localparam int QBIT    = FRAC_W - 1;
    localparam int MODE_W  = 4;

    typedef enum logic [1:0] {
        FAM_NUM08  = 2'd0,
        FAM_PROP19 = 2'd1,
        FAM_NUM19  = 2'd2,
        FAM_CSEL   = 2'd3
    } fam_e;

    typedef struct packed {
        logic use_mag;
        fam_e fam;
        logic want_max;
    } mode_t;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_zero;
    } opclass_t;

    function automatic logic [DATA_W-1:0] quieten(input logic [DATA_W-1:0] x);
        logic [DATA_W-1:0] y;
        y = x;
        y[QBIT] = 1'b1;
        return y;
    endfunction
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
    import fmm_pkg::*;
(
    input  logic [DATA_W-1:0] value,
    output opclass_t          cls
);
    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones    = &value[DATA_W-2:FRAC_W];
        frac_nz     = |value[FRAC_W-1:0];
        cls.is_nan  = exp_ones && frac_nz;
        cls.is_snan = exp_ones && frac_nz && !value[QBIT];
        cls.is_zero = ~|value[DATA_W-2:0];
    end
endmodule

// File: rtl/fmm_order.sv
module fmm_order
    import fmm_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              use_mag,
    input  logic              zero_split,
    output logic              a_lt_b,
    output logic              b_lt_a
);
    logic [DATA_W-2:0] ma;
    logic [DATA_W-2:0] mb;
    logic mag_lt;
    logic mag_gt;
    logic both_zero;
    logic s_lt;
    logic s_gt;

    always_comb begin
        ma        = a[DATA_W-2:0];
        mb        = b[DATA_W-2:0];
        mag_lt    = ma < mb;
        mag_gt    = ma > mb;
        both_zero = (ma == '0) && (mb == '0);
        if (a[DATA_W-1] != b[DATA_W-1]) begin
            if (both_zero && !zero_split) begin
                s_lt = 1'b0;
                s_gt = 1'b0;
            end else begin
                s_lt = a[DATA_W-1];
                s_gt = b[DATA_W-1];
            end
        end else if (a[DATA_W-1]) begin
            s_lt = mag_gt;
            s_gt = mag_lt;
        end else begin
            s_lt = mag_lt;
            s_gt = mag_gt;
        end
        if (use_mag && (mag_lt || mag_gt)) begin
            a_lt_b = mag_lt;
            b_lt_a = mag_gt;
        end else begin
            a_lt_b = s_lt;
            b_lt_a = s_gt;
        end
    end
endmodule

// File: rtl/fmm_select.sv
module fmm_select
    import fmm_pkg::*;
(
    input  mode_t             md,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  opclass_t          ca,
    input  opclass_t          cb,
    input  logic              a_lt_b,
    input  logic              b_lt_a,
    output logic [DATA_W-1:0] res,
    output logic              inv
);
    logic [DATA_W-1:0] ordered;
    logic any_snan;
    logic any_nan;

    always_comb begin
        ordered  = (md.want_max ? a_lt_b : b_lt_a) ? b : a;
        any_snan = ca.is_snan || cb.is_snan;
        any_nan  = ca.is_nan || cb.is_nan;
        inv      = any_snan;
        res      = ordered;
        unique case (md.fam)
            FAM_NUM08: begin
                if (any_snan)                    res = quieten(ca.is_snan ? a : b);
                else if (ca.is_nan && cb.is_nan) res = a;
                else if (ca.is_nan)              res = b;
                else if (cb.is_nan)              res = a;
            end
            FAM_PROP19: begin
                if (ca.is_nan)      res = quieten(a);
                else if (cb.is_nan) res = quieten(b);
            end
            FAM_NUM19: begin
                if (ca.is_nan && cb.is_nan) res = quieten(a);
                else if (ca.is_nan)         res = b;
                else if (cb.is_nan)         res = a;
            end
            FAM_CSEL: begin
                if (any_nan) res = cb.is_nan ? quieten(b) : b;
            end
            default: res = ordered;
        endcase
    end
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
    import fmm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              rc_in,
    input  logic [MODE_W-1:0] mode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              invalid,
    output logic              record
);
    localparam int NOPS = 2;

    mode_t             md;
    logic [DATA_W-1:0] ops [NOPS];
    opclass_t          cls [NOPS];
    logic              a_lt_b;
    logic              b_lt_a;
    logic              zero_split;
    logic [DATA_W-1:0] sel_res;
    logic              sel_inv;

    assign md     = mode_t'(mode);
    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign zero_split = (md.fam == FAM_PROP19) || (md.fam == FAM_NUM19);

    for (genvar g = 0; g < NOPS; g++) begin : g_cls
        fmm_classify u_cls (
            .value (ops[g]),
            .cls   (cls[g])
        );
    end

    fmm_order u_ord (
        .a          (op_a),
        .b          (op_b),
        .use_mag    (md.use_mag),
        .zero_split (zero_split),
        .a_lt_b     (a_lt_b),
        .b_lt_a     (b_lt_a)
    );

    fmm_select u_sel (
        .md     (md),
        .a      (op_a),
        .b      (op_b),
        .ca     (cls[0]),
        .cb     (cls[1]),
        .a_lt_b (a_lt_b),
        .b_lt_a (b_lt_a),
        .res    (sel_res),
        .inv    (sel_inv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            invalid   <= 1'b0;
            record    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            record    <= in_valid && rc_in;
            invalid   <= in_valid && sel_inv;
            if (in_valid) result <= sel_res;
        end
    end
endmodule

// File: rtl/fmm_unit_chk.sv
module fmm_unit_chk
    import fmm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              rc_in,
    input logic [MODE_W-1:0] mode,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              invalid,
    input logic              record
);
    function automatic logic nan_of(input logic [DATA_W-1:0] x);
        return (&x[DATA_W-2:FRAC_W]) && (|x[FRAC_W-1:0]);
    endfunction

    function automatic logic sig_of(input logic [DATA_W-1:0] x);
        return nan_of(x) && !x[QBIT];
    endfunction

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R2
    record_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        record |-> out_valid);
    // R11
    invalid_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        invalid |-> out_valid);
    // R11
    snan_raises_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (sig_of(op_a) || sig_of(op_b))) |=> invalid);
    // R10
    nan_out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && nan_of(result)) |-> result[QBIT]);
    // R7
    prop_keeps_nan_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode[2:1] == 2'd1 && (nan_of(op_a) || nan_of(op_b)))
        |=> nan_of(result));
endmodule

bind fmm_unit fmm_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .rc_in     (rc_in),
    .mode      (mode),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result),
    .invalid   (invalid),
    .record    (record)
);

// File: tb/sim_fmm_unit.sv
module sim_fmm_unit;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        rc_in = 1'b0;
    logic [3:0]  mode = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        invalid;
    logic        record;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    localparam logic [63:0] P1  = 64'h3FF0000000000000;
    localparam logic [63:0] P2  = 64'h4000000000000000;
    localparam logic [63:0] M1  = 64'hBFF0000000000000;
    localparam logic [63:0] M2  = 64'hC000000000000000;
    localparam logic [63:0] PZ  = 64'h0000000000000000;
    localparam logic [63:0] NZ  = 64'h8000000000000000;
    localparam logic [63:0] QN  = 64'h7FF8000000000000;
    localparam logic [63:0] NQN = 64'hFFF8000000000005;
    localparam logic [63:0] SN  = 64'h7FF0000000000001;
    localparam logic [63:0] NSN = 64'hFFF0000000000777;
    localparam logic [63:0] INF = 64'h7FF0000000000000;

    always #(PERIOD/2) clk = ~clk;

    fmm_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .rc_in(rc_in), .mode(mode),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result),
        .invalid(invalid), .record(record)
    );

    function automatic bit is_nan(input logic [63:0] x);
        return x[62:52] == 11'h7FF && x[51:0] != 0;
    endfunction
    function automatic bit is_sig(input logic [63:0] x);
        return is_nan(x) && x[51] == 1'b0;
    endfunction
    function automatic logic [63:0] q(input logic [63:0] x);
        return x | 64'h0008000000000000;
    endfunction
    function automatic logic [63:0] okey(input logic [63:0] x);
        return x[63] ? ~x : (x | 64'h8000000000000000);
    endfunction

    // -1: a before b, 0: tie, 1: b before a
    function automatic int order(input logic [63:0] a, input logic [63:0] b,
                                 input bit mag, input bit split);
        logic [63:0] ka, kb;
        if (mag && a[62:0] != b[62:0]) return (a[62:0] < b[62:0]) ? -1 : 1;
        if (!split && a[62:0] == 0 && b[62:0] == 0) return 0;
        ka = okey(a);
        kb = okey(b);
        if (ka == kb) return 0;
        return (ka < kb) ? -1 : 1;
    endfunction

    function automatic logic [63:0] ref_res(input logic [63:0] a, input logic [63:0] b,
                                            input logic [3:0] m);
        int o;
        bit na, nb;
        logic [63:0] pick;
        na = is_nan(a);
        nb = is_nan(b);
        o = order(a, b, m[3], m[2:1] == 2'd1 || m[2:1] == 2'd2);
        if (m[0]) pick = (o < 0) ? b : a;
        else      pick = (o > 0) ? b : a;
        case (m[2:1])
            2'd0: begin
                if (is_sig(a)) return q(a);
                if (is_sig(b)) return q(b);
                if (na) return nb ? a : b;
                if (nb) return a;
            end
            2'd1: begin
                if (na) return q(a);
                if (nb) return q(b);
            end
            2'd2: begin
                if (na && nb) return q(a);
                if (na) return b;
                if (nb) return a;
            end
            default: if (na || nb) return nb ? q(b) : b;
        endcase
        return pick;
    endfunction

    task automatic report(input string tag, input bit ok, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // called at a negedge; output checked at the next negedge
    task automatic run(input logic [63:0] a, input logic [63:0] b,
                       input logic [3:0] m, input bit rc, input string tag);
        logic [63:0] er;
        bit ei;
        er = ref_res(a, b, m);
        ei = is_sig(a) || is_sig(b);
        op_a = a; op_b = b; mode = m; rc_in = rc; in_valid = 1'b1;
        @(negedge clk);
        report(tag, out_valid === 1'b1 && result === er && invalid === ei && record === rc,
               $sformatf("mode=%h a=%h b=%h actual res=%h inv=%b rec=%b v=%b expected res=%h inv=%b rec=%b v=1",
                         m, a, b, result, invalid, record, out_valid, er, ei, rc));
    endtask

    initial begin
        #(PERIOD*150000);
        if (!done) begin
            report("watchdog", 1'b0, "actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] pool [11];
        pool = '{P1, P2, M1, M2, PZ, NZ, QN, NQN, SN, NSN, INF};
        in_valid = 1'b1; rc_in = 1'b1; op_a = SN; op_b = P1;
        repeat (3) @(negedge clk);
        // R1 reset state
        report("R1", out_valid === 1'b0 && result === 64'h0 && invalid === 1'b0 && record === 1'b0,
               $sformatf("actual v=%b res=%h inv=%b rec=%b expected all zero",
                         out_valid, result, invalid, record));
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        // R3 ordinary min/max
        run(P1, P2, 4'h0, 1'b0, "R3");
        run(P1, P2, 4'h1, 1'b1, "R3");
        run(M2, P1, 4'h6, 1'b0, "R3");
        run(INF, M1, 4'h7, 1'b0, "R3");
        // R4 magnitude
        run(M2, P1, 4'h8, 1'b0, "R4");
        run(M2, P1, 4'h9, 1'b0, "R4");
        run(M1, P1, 4'hC, 1'b0, "R4");
        run(P1, M1, 4'hD, 1'b0, "R4");
        run(PZ, NZ, 4'hA, 1'b0, "R4");
        // R5 signed zeros
        run(PZ, NZ, 4'h2, 1'b0, "R5");
        run(NZ, PZ, 4'h5, 1'b0, "R5");
        run(PZ, NZ, 4'h0, 1'b0, "R5");
        run(NZ, PZ, 4'h1, 1'b0, "R5");
        run(PZ, NZ, 4'h6, 1'b0, "R5");
        // R6 number-2008
        run(QN, P1, 4'h0, 1'b0, "R6");
        run(P1, NQN, 4'h1, 1'b0, "R6");
        run(P1, SN, 4'h0, 1'b0, "R6");
        run(NQN, QN, 4'h1, 1'b0, "R6");
        run(QN, NSN, 4'h0, 1'b0, "R6");
        // R7 propagating
        run(P1, QN, 4'h2, 1'b0, "R7");
        run(SN, NQN, 4'h3, 1'b0, "R7");
        // R8 number-2019
        run(SN, M1, 4'h4, 1'b0, "R8");
        run(P2, QN, 4'h5, 1'b0, "R8");
        run(NSN, SN, 4'h4, 1'b0, "R8");
        // R9 compare-select
        run(QN, P1, 4'h6, 1'b0, "R9");
        run(P1, SN, 4'h7, 1'b0, "R9");
        // R10/R11 quieting and flag
        run(NSN, P2, 4'h2, 1'b1, "R10");
        run(M1, NSN, 4'hE, 1'b1, "R11");
        // R2 idle and record
        in_valid = 1'b0;
        @(negedge clk);
        report("R2", out_valid === 1'b0 && record === 1'b0 && invalid === 1'b0,
               $sformatf("actual v=%b rec=%b inv=%b expected 0 0 0", out_valid, record, invalid));
        for (int i = 0; i < 600; i++) begin
            logic [3:0] m;
            m = 4'($urandom % 16);
            run(pool[$urandom % 11], pool[$urandom % 11], m, 1'($urandom % 2),
                m[3] ? "R4" : (m[2:1] == 2'd0 ? "R6" : m[2:1] == 2'd1 ? "R7" :
                               m[2:1] == 2'd2 ? "R8" : "R9"));
        end
        in_valid = 1'b0;
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule